// File: doc/BRIEF.md
# Branch Delay Slot Fetch Controller

This block steers the program counter and holds a single fetched instruction for a two-phase core whose architecture has branch delay slots. On every enabled step it latches the word read from instruction memory into a one-entry slot. In the same step it presents the word that was already in the slot to the execute side. A taken branch or jump therefore always lets one following instruction run: the one sitting in the slot. That slot is then marked as a delay-slot instruction.

Decode results for the executing instruction come back on plain control pins in the same step: branch taken, branch likely, the 16-bit immediate, jump taken with its target, exception and stop. From these the block picks the next fetch address. It also does three other things:
- It turns the slot into a bubble when a branch-likely is not taken.
- It freezes the PC and drops the slot when the executing instruction raises an exception or asks to stop.
- It gives the exception logic the faulting address, the address of the previously completed instruction, the delay-slot flag and the restart address.

There is no back-pressure: one step is one `step_en` pulse. Instruction memory is read combinationally at `imem_addr`. A step with `step_en` low changes nothing.

Top module: `branch_slot_fetch`

## Requirements
- R1: While reset is held and after it is released, the PC is RESET_PC (0). The slot is a bubble: valid 0, instruction word 0, address 0, delay-slot flag 0. The previous-address register is 0.
- R2: A step with `step_en` low changes no state. In a normal step the slot takes `imem_rdata`, takes `imem_addr` as its address, and sets valid to 1.
- R3: When the executing instruction is valid and is neither a taken branch nor a taken jump, and no exception or stop is raised, the PC advances by 4.
- R4: For a taken branch, the next PC is the executing instruction's address plus 4 plus the immediate. The immediate is shifted left by 2 and sign-extended from bit 17.
- R5: For a taken jump, the next PC is `jmp_target`. A jump takes priority over a branch.
- R6: The instruction latched in the step of a taken branch or jump carries delay-slot flag 1. Every other latched instruction carries 0, and a bubble always carries 0.
- R7: A valid branch-likely whose branch is not taken, with no jump, turns the slot into a bubble (all zero) instead of latching the fetched word.
- R8: When a valid executing instruction raises an exception or a stop, the slot becomes a bubble and the PC keeps its value.
- R9: `exc_report` is high exactly when `step_en`, a valid executing instruction and `exc_raise` are all high. At that time the block drives:
  - `exc_fault_addr` as the executing address;
  - `exc_fault_in_ds` as its delay-slot flag;
  - `exc_prev_addr` as the stored previous address;
  - `exc_restart_pc` as the current PC.
- R10: After each step in which a valid instruction completes without an exception (a stop included), that instruction's address becomes the previous address, shown on `exc_prev_addr`.
- R11: While the slot holds a bubble, the branch, likely, jump, exception and stop inputs have no effect. The PC advances by 4 and the fetched word is latched with delay-slot flag 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step_en | input | 1 | Advance one step |
| imem_addr | output | AW | Fetch address (current PC) |
| imem_rdata | input | IW | Instruction word at `imem_addr` |
| exec_instr | output | IW | Instruction handed to execute |
| exec_addr | output | AW | Address of the executing instruction |
| exec_valid | output | 1 | Executing instruction is real, not a bubble |
| exec_in_ds | output | 1 | Executing instruction sits in a delay slot |
| br_taken | input | 1 | Executing branch is taken |
| br_likely | input | 1 | Executing branch is a likely variant |
| br_imm | input | IMMW | Branch immediate |
| jmp_taken | input | 1 | Executing instruction is a jump |
| jmp_target | input | AW | Jump destination |
| exc_raise | input | 1 | Executing instruction faulted |
| stop_req | input | 1 | Executing instruction requests a stop |
| exc_report | output | 1 | Exception context is valid this step |
| exc_fault_addr | output | AW | Faulting instruction address |
| exc_prev_addr | output | AW | Last completed instruction address |
| exc_fault_in_ds | output | 1 | Faulting instruction was in a delay slot |
| exc_restart_pc | output | AW | PC held for restart |

## Verification
The bench builds the block with its defaults: a 32-bit address, 32-bit words and a 16-bit immediate.

A branch sweep steps the immediate by 257 across the whole 16-bit range and adds both sign extremes. This reaches backward and forward targets, the offset sign boundary and address wrap-around.

A long pseudo-random run then mixes several kinds of step:
- idle steps;
- bubbles;
- jumps over branches;
- likely nullification;
- stops and exceptions, including back to back.

Every step is compared against an arithmetic model of the next PC, the slot contents and the previous address.

// File: rtl/fdc_pkg.sv
package fdc_pkg;
  // source chosen for the next fetch address
  typedef enum logic [1:0] {
    PC_SEQ    = 2'd0,
    PC_BRANCH = 2'd1,
    PC_JUMP   = 2'd2,
    PC_HOLD   = 2'd3
  } pc_sel_e;
endpackage

// File: rtl/fdc_pc_unit.sv
module fdc_pc_unit
  import fdc_pkg::*;
#(
  parameter int unsigned    AW       = 32,
  parameter int unsigned    IMMW     = 16,
  parameter logic [AW-1:0]  RESET_PC = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step_en,
  input  pc_sel_e       sel,
  input  logic [AW-1:0] exec_addr,
  input  logic [IMMW-1:0] imm,
  input  logic [AW-1:0] jmp_target,
  output logic [AW-1:0] pc
);
  localparam int unsigned    OFFW  = IMMW + 2;
  localparam int             EXTW  = int'(AW) - int'(OFFW);
  localparam logic [AW-1:0]  STEP4 = AW'(4);

  logic [OFFW-1:0] off_raw;
  logic [AW-1:0]   off_ext;
  logic [AW-1:0]   br_target;
  logic [AW-1:0]   pc_nxt;

  assign off_raw = {imm, 2'b00};

  generate
    if (EXTW > 0) begin : g_sext
      assign off_ext = {{EXTW{off_raw[OFFW-1]}}, off_raw};
    end else begin : g_trunc
      assign off_ext = off_raw[AW-1:0];
    end
  endgenerate

  assign br_target = exec_addr + STEP4 + off_ext;

  always_comb begin
    unique case (sel)
      PC_BRANCH: pc_nxt = br_target;
      PC_JUMP:   pc_nxt = jmp_target;
      PC_HOLD:   pc_nxt = pc;
      default:   pc_nxt = pc + STEP4;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc <= RESET_PC;
    end else if (step_en) begin
      pc <= pc_nxt;
    end
  end
endmodule

// File: rtl/fdc_fetch_slot.sv
module fdc_fetch_slot #(
  parameter int unsigned AW = 32,
  parameter int unsigned IW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step_en,
  input  logic          kill,
  input  logic [IW-1:0] in_instr,
  input  logic [AW-1:0] in_addr,
  input  logic          in_ds,
  output logic          slot_valid,
  output logic [IW-1:0] slot_instr,
  output logic [AW-1:0] slot_addr,
  output logic          slot_ds
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_valid <= 1'b0;
      slot_instr <= '0;
      slot_addr  <= '0;
      slot_ds    <= 1'b0;
    end else if (step_en) begin
      if (kill) begin
        slot_valid <= 1'b0;
        slot_instr <= '0;
        slot_addr  <= '0;
        slot_ds    <= 1'b0;
      end else begin
        slot_valid <= 1'b1;
        slot_instr <= in_instr;
        slot_addr  <= in_addr;
        slot_ds    <= in_ds;
      end
    end
  end
endmodule

// File: rtl/fdc_exc_ctx.sv
module fdc_exc_ctx #(
  parameter int unsigned AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step_en,
  input  logic          exec_valid,
  input  logic          exc_raise,
  input  logic [AW-1:0] exec_addr,
  input  logic          exec_in_ds,
  input  logic [AW-1:0] pc,
  output logic          report,
  output logic [AW-1:0] fault_addr,
  output logic [AW-1:0] prev_addr,
  output logic          fault_in_ds,
  output logic [AW-1:0] restart_pc
);
  logic completes;

  assign completes = step_en & exec_valid & ~exc_raise;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_addr <= '0;
    end else if (completes) begin
      prev_addr <= exec_addr;
    end
  end

  assign report      = step_en & exec_valid & exc_raise;
  assign fault_addr  = exec_addr;
  assign fault_in_ds = exec_in_ds;
  assign restart_pc  = pc;
endmodule

// File: rtl/branch_slot_fetch.sv
module branch_slot_fetch
  import fdc_pkg::*;
#(
  parameter int unsigned   AW       = 32,
  parameter int unsigned   IW       = 32,
  parameter int unsigned   IMMW     = 16,
  parameter logic [AW-1:0] RESET_PC = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            step_en,
  output logic [AW-1:0]   imem_addr,
  input  logic [IW-1:0]   imem_rdata,
  output logic [IW-1:0]   exec_instr,
  output logic [AW-1:0]   exec_addr,
  output logic            exec_valid,
  output logic            exec_in_ds,
  input  logic            br_taken,
  input  logic            br_likely,
  input  logic [IMMW-1:0] br_imm,
  input  logic            jmp_taken,
  input  logic [AW-1:0]   jmp_target,
  input  logic            exc_raise,
  input  logic            stop_req,
  output logic            exc_report,
  output logic [AW-1:0]   exc_fault_addr,
  output logic [AW-1:0]   exc_prev_addr,
  output logic            exc_fault_in_ds,
  output logic [AW-1:0]   exc_restart_pc
);
  logic          live_exc;
  logic          live_stop;
  logic          halt;
  logic          live_jump;
  logic          live_branch;
  logic          redirect;
  logic          nullify;
  logic          kill;
  pc_sel_e       sel;
  logic [AW-1:0] pc;

  // decode outputs only count when a real instruction executes
  assign live_exc    = exec_valid & exc_raise;
  assign live_stop   = exec_valid & stop_req;
  assign halt        = live_exc | live_stop;
  assign live_jump   = exec_valid & jmp_taken;
  assign live_branch = exec_valid & br_taken;
  assign redirect    = live_jump | live_branch;
  assign nullify     = exec_valid & br_likely & ~br_taken & ~jmp_taken;
  assign kill        = halt | nullify;

  always_comb begin
    if (halt)             sel = PC_HOLD;
    else if (live_jump)   sel = PC_JUMP;
    else if (live_branch) sel = PC_BRANCH;
    else                  sel = PC_SEQ;
  end

  fdc_pc_unit #(
    .AW       (AW),
    .IMMW     (IMMW),
    .RESET_PC (RESET_PC)
  ) u_pc (
    .clk        (clk),
    .rst_n      (rst_n),
    .step_en    (step_en),
    .sel        (sel),
    .exec_addr  (exec_addr),
    .imm        (br_imm),
    .jmp_target (jmp_target),
    .pc         (pc)
  );

  fdc_fetch_slot #(
    .AW (AW),
    .IW (IW)
  ) u_slot (
    .clk        (clk),
    .rst_n      (rst_n),
    .step_en    (step_en),
    .kill       (kill),
    .in_instr   (imem_rdata),
    .in_addr    (pc),
    .in_ds      (redirect),
    .slot_valid (exec_valid),
    .slot_instr (exec_instr),
    .slot_addr  (exec_addr),
    .slot_ds    (exec_in_ds)
  );

  fdc_exc_ctx #(
    .AW (AW)
  ) u_exc (
    .clk         (clk),
    .rst_n       (rst_n),
    .step_en     (step_en),
    .exec_valid  (exec_valid),
    .exc_raise   (exc_raise),
    .exec_addr   (exec_addr),
    .exec_in_ds  (exec_in_ds),
    .pc          (pc),
    .report      (exc_report),
    .fault_addr  (exc_fault_addr),
    .prev_addr   (exc_prev_addr),
    .fault_in_ds (exc_fault_in_ds),
    .restart_pc  (exc_restart_pc)
  );

  assign imem_addr = pc;
endmodule

// File: rtl/fdc_checker.sv
module fdc_checker #(
  parameter int unsigned AW = 32,
  parameter int unsigned IW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          step_en,
  input logic [AW-1:0] imem_addr,
  input logic [IW-1:0] exec_instr,
  input logic [AW-1:0] exec_addr,
  input logic          exec_valid,
  input logic          exec_in_ds,
  input logic          br_taken,
  input logic          br_likely,
  input logic          jmp_taken,
  input logic          exc_raise,
  input logic          stop_req,
  input logic          exc_report
);
  logic plain_step;
  assign plain_step = step_en & exec_valid & ~br_taken & ~jmp_taken & ~exc_raise & ~stop_req;

  AST_SEQ_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    plain_step |=> imem_addr == $past(imem_addr) + AW'(4)); // R3

  AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !step_en |=> $stable(imem_addr) && $stable(exec_addr) && $stable(exec_valid)); // R2

  AST_HALT_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && exec_valid && (exc_raise || stop_req)) |=> !exec_valid && $stable(imem_addr)); // R8

  AST_BUBBLE_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    !exec_valid |-> !exec_in_ds && exec_instr == '0 && exec_addr == '0); // R6

  AST_LIKELY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (plain_step && br_likely) |=> !exec_valid); // R7

  AST_REPORT_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    exc_report |-> exec_valid && step_en); // R9
endmodule

bind branch_slot_fetch fdc_checker #(.AW(AW), .IW(IW)) u_fdc_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .step_en    (step_en),
  .imem_addr  (imem_addr),
  .exec_instr (exec_instr),
  .exec_addr  (exec_addr),
  .exec_valid (exec_valid),
  .exec_in_ds (exec_in_ds),
  .br_taken   (br_taken),
  .br_likely  (br_likely),
  .jmp_taken  (jmp_taken),
  .exc_raise  (exc_raise),
  .stop_req   (stop_req),
  .exc_report (exc_report)
);

// File: tb/test_branch_slot_fetch.sv
`timescale 1ns/100ps
module test_branch_slot_fetch;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        step_en;
  logic [31:0] imem_addr;
  logic [31:0] imem_rdata;
  logic [31:0] exec_instr;
  logic [31:0] exec_addr;
  logic        exec_valid;
  logic        exec_in_ds;
  logic        br_taken;
  logic        br_likely;
  logic [15:0] br_imm;
  logic        jmp_taken;
  logic [31:0] jmp_target;
  logic        exc_raise;
  logic        stop_req;
  logic        exc_report;
  logic [31:0] exc_fault_addr;
  logic [31:0] exc_prev_addr;
  logic        exc_fault_in_ds;
  logic [31:0] exc_restart_pc;

  always #2.5 clk = ~clk;

  // instruction memory: word derived from its address, never zero
  assign imem_rdata = {~imem_addr[15:0], imem_addr[15:0]};

  branch_slot_fetch i_branch_slot_fetch (
    .clk(clk), .rst_n(rst_n), .step_en(step_en),
    .imem_addr(imem_addr), .imem_rdata(imem_rdata),
    .exec_instr(exec_instr), .exec_addr(exec_addr),
    .exec_valid(exec_valid), .exec_in_ds(exec_in_ds),
    .br_taken(br_taken), .br_likely(br_likely), .br_imm(br_imm),
    .jmp_taken(jmp_taken), .jmp_target(jmp_target),
    .exc_raise(exc_raise), .stop_req(stop_req),
    .exc_report(exc_report), .exc_fault_addr(exc_fault_addr),
    .exc_prev_addr(exc_prev_addr), .exc_fault_in_ds(exc_fault_in_ds),
    .exc_restart_pc(exc_restart_pc)
  );

  int unsigned n_cmp = 0;
  int unsigned n_bad = 0;
  bit          done  = 1'b0;

  // reference state
  logic [31:0] m_pc, m_i, m_a, m_prev;
  logic        m_v, m_ds;

  function automatic logic [31:0] word_at(logic [31:0] a);
    return {~a[15:0], a[15:0]};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_state(string tag);
    chk({tag, " pc"}, imem_addr, m_pc);
    chk("R2 slot valid", 32'(exec_valid), 32'(m_v));
    chk("R2 slot instr", exec_instr, m_i);
    chk("R2 slot addr", exec_addr, m_a);
    chk("R6 delay-slot flag", 32'(exec_in_ds), 32'(m_ds));
    chk("R10 prev addr", exc_prev_addr, m_prev);
  endtask

  task automatic step(bit en, bit br, bit lk, logic [15:0] imm, bit jp,
                      logic [31:0] jt, bit ex, bit st);
    string       tag;
    logic [31:0] n_pc, n_i, n_a, n_prev, off;
    logic        n_v, n_ds;
    @(negedge clk);
    step_en = en; br_taken = br; br_likely = lk; br_imm = imm;
    jmp_taken = jp; jmp_target = jt; exc_raise = ex; stop_req = st;
    #0.5;
    chk("R9 report", 32'(exc_report), 32'(en & m_v & ex));
    if (en && m_v && ex) begin
      chk("R9 fault addr", exc_fault_addr, m_a);
      chk("R9 fault ds", 32'(exc_fault_in_ds), 32'(m_ds));
      chk("R9 prev addr", exc_prev_addr, m_prev);
      chk("R9 restart pc", exc_restart_pc, m_pc);
    end
    n_pc = m_pc; n_v = m_v; n_i = m_i; n_a = m_a; n_ds = m_ds; n_prev = m_prev;
    off = {{16{imm[15]}}, imm} << 2;
    if (!en) begin
      tag = "R2 idle";
    end else if (!m_v) begin
      tag = "R11 bubble";
      n_pc = m_pc + 32'd4;
      n_v = 1'b1; n_i = word_at(m_pc); n_a = m_pc; n_ds = 1'b0;
    end else begin
      if (!ex) n_prev = m_a;
      if (ex || st) begin
        tag = "R8 halt";
        n_pc = m_pc;
        n_v = 1'b0; n_i = '0; n_a = '0; n_ds = 1'b0;
      end else begin
        if (jp) begin
          tag = "R5 jump"; n_pc = jt;
        end else if (br) begin
          tag = "R4 branch"; n_pc = m_a + 32'd4 + off;
        end else begin
          tag = "R3 sequential"; n_pc = m_pc + 32'd4;
        end
        if (lk && !br && !jp) begin
          tag = "R7 likely drop";
          n_v = 1'b0; n_i = '0; n_a = '0; n_ds = 1'b0;
        end else begin
          n_v = 1'b1; n_i = word_at(m_pc); n_a = m_pc; n_ds = br | jp;
        end
      end
    end
    @(posedge clk);
    #1;
    m_pc = n_pc; m_v = n_v; m_i = n_i; m_a = n_a; m_ds = n_ds; m_prev = n_prev;
    check_state(tag);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; step_en = 1'b1; br_taken = 1'b0; br_likely = 1'b0;
    br_imm = '0; jmp_taken = 1'b0; jmp_target = '0; exc_raise = 1'b0; stop_req = 1'b0;
    m_pc = '0; m_v = 1'b0; m_i = '0; m_a = '0; m_ds = 1'b0; m_prev = '0;
    repeat (3) @(posedge clk);
    #1;
    check_state("R1 in reset");
    @(negedge clk);
    rst_n = 1'b1;
    step_en = 1'b0;
    #1;
    check_state("R1 after reset");

    // R11: a bubble ignores every decode input
    step(1, 1, 1, 16'h0040, 1, 32'h0000_8000, 1, 1);
    // R2: idle steps with noisy inputs change nothing
    for (int k = 0; k < 4; k++)
      step(0, 1, 0, 16'h1234, 1, 32'h0000_4000, 1, 0);

    // R4: immediate sweep, each branch followed by its delay slot
    for (int k = 0; k < 258; k++) begin
      logic [15:0] imm;
      imm = (k == 256) ? 16'h8000 : (k == 257) ? 16'h7FFF : 16'(k * 257);
      step(1, 1, k[0], imm, 0, '0, 0, 0);
      step(1, 0, 0, '0, 0, '0, 0, 0);
    end

    // R7: likely not taken right after a fill, then refill
    step(1, 0, 1, 16'h0010, 0, '0, 0, 0);
    step(1, 0, 0, '0, 0, '0, 0, 0);
    step(1, 0, 0, '0, 0, '0, 0, 0);
    // R5: jump wins over branch
    step(1, 1, 0, 16'h0100, 1, 32'h0000_2000, 0, 0);
    step(1, 0, 0, '0, 0, '0, 0, 0);
    // R9: exception from the delay slot of a taken branch
    step(1, 1, 0, 16'h0008, 0, '0, 0, 0);
    step(1, 0, 0, '0, 0, '0, 1, 0);
    step(1, 0, 0, '0, 0, '0, 0, 0);
    // R8: stop, then back-to-back exceptions
    step(1, 0, 0, '0, 0, '0, 0, 0);
    step(1, 0, 0, '0, 0, '0, 0, 1);
    step(1, 0, 0, '0, 0, '0, 0, 0);
    step(1, 0, 0, '0, 0, '0, 1, 0);
    step(1, 0, 0, '0, 0, '0, 1, 0);
    step(1, 0, 0, '0, 0, '0, 0, 0);

    // mixed pseudo-random run
    for (int k = 0; k < 3000; k++) begin
      logic [31:0] r;
      r = $urandom;
      step((r[2:0] != 3'd0), (r[4:3] == 2'd0), (r[6:5] == 2'd0), r[22:7],
           (r[25:23] == 3'd0), {16'h0, r[31:18], 2'b00},
           (r[29:26] == 4'd0), (r[30:27] == 4'd1));
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule